// File: doc/BRIEF.md
# Transmit Trigger and Interrupt Controller

This block gives a host a small register window for sending one frame from the normal transmit buffer and for collecting events. The host writes a control register to start a send and to say whether the frame should wait for an acknowledgement. The block raises a request towards a simplified MAC model and holds it until the MAC accepts it. It then latches the completion and retry-failure results that the MAC returns.

Two events are latched in an event register: transmit complete and frame received. Each event has its own mask bit in which a 1 disables it. An active-low level interrupt line is asserted while any latched event is unmasked. Reading the event register clears it. After a completion interrupt the host reads a separate transmit-result register to learn whether the retry count ran out.

The host port is a plain synchronous register interface with a 2-bit address and 8-bit data. Read data is combinational from the addressed register. Addresses are 0 for transmit control, 1 for transmit result, 2 for events and 3 for masks.

Top module: `txirq_top`

## Requirements
- R1: After reset, irqN is 1, macReq and macAckReq are 0, and the registers read back as: transmit control 0x00, transmit result 0x00, events 0x00, masks 0x09 (both events disabled).
- R2: A write to address 0 with bit 0 set raises macReq in the following cycle, and transmit control then reads back with bit 0 set.
- R3: macReq stays high while macAccept is low. In the cycle after macAccept is seen with macReq high, macReq is 0 and bit 0 of transmit control reads 0.
- R4: Bit 2 written to address 0 is driven on macAckReq and reads back in bit 2 of transmit control until the next write to address 0.
- R5: A macDone pulse sets bit 0 of the event register and an rxEvent pulse sets bit 3. All other event bits read 0.
- R6: When macDone is high, bit 0 of the transmit-result register takes the value of macFail (1 means retries exhausted, 0 means success). It holds until a write to address 0 with bit 0 set clears it.
- R7: A read of address 2 returns the latched events and clears them from the next cycle on.
- R8: An event that arrives in the same cycle as a read of address 2 stays latched after that read.
- R9: Mask bits 0 and 3 at address 3 disable the matching event when 1. irqN is 0 exactly when a latched event has its mask bit at 0. A masked event stays latched and visible in the event register.
- R10: Only bits 0 and 3 of the mask register are stored. All other mask bits read 0.
- R11: Writes to addresses 1 and 2 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 2 | Register address |
| regWr | input | 1 | Write strobe |
| regRd | input | 1 | Read strobe (clears events when the address is 2) |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data of the addressed register |
| macReq | output | 1 | Transmit request to the MAC |
| macAckReq | output | 1 | Frame expects an acknowledgement |
| macAccept | input | 1 | MAC takes the request |
| macDone | input | 1 | MAC finished the frame (one-cycle pulse) |
| macFail | input | 1 | Retries exhausted, valid with macDone |
| rxEvent | input | 1 | Frame-received pulse |
| irqN | output | 1 | Active-low level interrupt |

## Verification
The assertions check on every cycle that the request is held and then dropped around the accept handshake, and that the trigger and acknowledgement flags follow host writes. They also check that the result bit follows macFail on completion, that an event arriving during a clearing read survives it, and that the interrupt line stays high whenever no event is latched. Only the bench's scenarios can show several things: the values returned by reads, the clear taking effect only after the read, the result bit being cleared by a new trigger, masked events staying visible, and writes to the read-only registers having no effect. A seeded random run mixes events, reads and mask writes against a reference model to cover collisions that the directed cases miss.

// File: rtl/txirq_pkg.sv
package txirq_pkg;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 8;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_RES  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_EVT  = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_MASK = 2'd3;
  localparam int BIT_TRIG = 0;
  localparam int BIT_ACK  = 2;
  localparam int BIT_FAIL = 0;
  localparam int EVT_N    = 2;
  // register bit position of each event, index 0 = tx done, 1 = rx
  localparam int EVT_POS [EVT_N] = '{0, 3};

  typedef struct packed {
    logic wrCtrl;
    logic startTx;
    logic wrMask;
    logic clrEvt;
  } hostStrobe_t;
endpackage

// File: rtl/txirq_ctrl.sv
module txirq_ctrl
  import txirq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic              trigBit,
  input  logic              macAccept,
  output hostStrobe_t       strobe,
  output logic              macReq
);
  logic trigQ;

  always_comb begin
    strobe.wrCtrl  = regWr && (regAddr == ADDR_CTRL);
    strobe.startTx = strobe.wrCtrl && trigBit;
    strobe.wrMask  = regWr && (regAddr == ADDR_MASK);
    strobe.clrEvt  = regRd && (regAddr == ADDR_EVT);
  end

  // trigger bit: set by host, self-clears when the MAC takes it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               trigQ <= 1'b0;
    else if (strobe.startTx) trigQ <= 1'b1;
    else if (macAccept)      trigQ <= 1'b0;
  end

  assign macReq = trigQ;
endmodule

// File: rtl/txirq_dp.sv
module txirq_dp
  import txirq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  hostStrobe_t       strobe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              macReq,
  input  logic              macDone,
  input  logic              macFail,
  input  logic              rxEvent,
  output logic [DATA_W-1:0] regRdata,
  output logic              macAckReq,
  output logic              irqN,
  output logic [EVT_N-1:0]  evtQ,
  output logic [EVT_N-1:0]  maskQ,
  output logic              failQ
);
  logic [EVT_N-1:0] evtSet;
  logic [EVT_N-1:0] maskIn;
  logic [DATA_W-1:0] evtView, maskView;
  logic ackQ;

  assign evtSet = {rxEvent, macDone};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              ackQ <= 1'b0;
    else if (strobe.wrCtrl) ackQ <= regWdata[BIT_ACK];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               failQ <= 1'b0;
    else if (macDone)        failQ <= macFail;
    else if (strobe.startTx) failQ <= 1'b0;
  end

  for (genvar i = 0; i < EVT_N; i++) begin : g_evt
    assign maskIn[i] = regWdata[EVT_POS[i]];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) evtQ[i] <= 1'b0;
      else       evtQ[i] <= evtSet[i] | (evtQ[i] & ~strobe.clrEvt);
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              maskQ[i] <= 1'b1;
      else if (strobe.wrMask) maskQ[i] <= maskIn[i];
    end
  end

  always_comb begin
    evtView  = '0;
    maskView = '0;
    for (int i = 0; i < EVT_N; i++) begin
      evtView[EVT_POS[i]]  = evtQ[i];
      maskView[EVT_POS[i]] = maskQ[i];
    end
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      ADDR_CTRL: begin
        regRdata[BIT_TRIG] = macReq;
        regRdata[BIT_ACK]  = ackQ;
      end
      ADDR_RES:  regRdata[BIT_FAIL] = failQ;
      ADDR_EVT:  regRdata = evtView;
      default:   regRdata = maskView;
    endcase
  end

  assign macAckReq = ackQ;
  assign irqN      = ~|(evtQ & ~maskQ);
endmodule

// File: rtl/txirq_top.sv
module txirq_top
  import txirq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              macReq,
  output logic              macAckReq,
  input  logic              macAccept,
  input  logic              macDone,
  input  logic              macFail,
  input  logic              rxEvent,
  output logic              irqN
);
  hostStrobe_t      strobe;
  logic [EVT_N-1:0] evtQ;
  logic [EVT_N-1:0] maskQ;
  logic             failQ;

  txirq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .trigBit(regWdata[BIT_TRIG]), .macAccept(macAccept),
    .strobe(strobe), .macReq(macReq)
  );

  txirq_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regAddr(regAddr),
    .regWdata(regWdata), .macReq(macReq), .macDone(macDone),
    .macFail(macFail), .rxEvent(rxEvent), .regRdata(regRdata),
    .macAckReq(macAckReq), .irqN(irqN), .evtQ(evtQ), .maskQ(maskQ),
    .failQ(failQ)
  );
endmodule

// File: rtl/txirq_chk.sv
module txirq_chk
  import txirq_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWr,
  input logic              regRd,
  input logic [DATA_W-1:0] regWdata,
  input logic              macReq,
  input logic              macAckReq,
  input logic              macAccept,
  input logic              macDone,
  input logic              macFail,
  input logic              rxEvent,
  input logic              irqN,
  input logic [EVT_N-1:0]  evtQ,
  input logic              failQ
);
  logic trigWr;
  assign trigWr = regWr && (regAddr == ADDR_CTRL) && regWdata[BIT_TRIG];

  AST_TRIG_RAISES: assert property (@(posedge clk) disable iff (!rstN)
    trigWr |=> macReq); // R2
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    macReq && !macAccept |=> macReq); // R3
  AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rstN)
    macReq && macAccept && !trigWr |=> !macReq); // R3
  AST_ACK_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    regWr && (regAddr == ADDR_CTRL) |=> macAckReq == $past(regWdata[BIT_ACK])); // R4
  AST_FAIL_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    macDone |=> failQ == $past(macFail)); // R6
  AST_DONE_SETS: assert property (@(posedge clk) disable iff (!rstN)
    macDone |=> evtQ[0]); // R5
  AST_EVT_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    regRd && (regAddr == ADDR_EVT) && rxEvent |=> evtQ[1]); // R8
  AST_QUIET_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (evtQ == '0) |-> irqN); // R9
endmodule

bind txirq_top txirq_chk u_chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
  .regWdata(regWdata), .macReq(macReq), .macAckReq(macAckReq),
  .macAccept(macAccept), .macDone(macDone), .macFail(macFail),
  .rxEvent(rxEvent), .irqN(irqN), .evtQ(evtQ), .failQ(failQ)
);

// File: tb/txirq_top_test.sv
`timescale 1ns/1ps
module txirq_top_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] regAddr = '0;
  logic       regWr = 1'b0, regRd = 1'b0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic       macReq, macAckReq, irqN;
  logic       macAccept = 1'b0, macDone = 1'b0, macFail = 1'b0, rxEvent = 1'b0;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  txirq_top uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata), .macReq(macReq),
    .macAckReq(macAckReq), .macAccept(macAccept), .macDone(macDone),
    .macFail(macFail), .rxEvent(rxEvent), .irqN(irqN)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); regAddr = a; regWr = 1'b1; regWdata = d;
    @(negedge clk); regWr = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); regAddr = a; regRd = 1'b1; #1 d = regRdata;
    @(negedge clk); regRd = 1'b0;
  endtask

  task automatic pulseDone(input logic fail);
    @(negedge clk); macDone = 1'b1; macFail = fail;
    @(negedge clk); macDone = 1'b0; macFail = 1'b0;
  endtask

  task automatic pulseRx();
    @(negedge clk); rxEvent = 1'b1;
    @(negedge clk); rxEvent = 1'b0;
  endtask

  function automatic logic [7:0] evtByte(input logic e0, input logic e1);
    return {4'b0, e1, 2'b0, e0};
  endfunction

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic mEv0, mEv1, mMk0, mMk1, mFail;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irqN", {7'b0, irqN}, 8'h01);
    chk("R1 macReq", {6'b0, macAckReq, macReq}, 8'h00);
    rdReg(2'd0, d); chk("R1 ctrl", d, 8'h00);
    rdReg(2'd1, d); chk("R1 result", d, 8'h00);
    rdReg(2'd2, d); chk("R1 events", d, 8'h00);
    rdReg(2'd3, d); chk("R1 mask", d, 8'h09);

    // R2 R4 trigger with ack request
    wrReg(2'd0, 8'h05);
    chk("R2 macReq", {7'b0, macReq}, 8'h01);
    chk("R4 macAckReq", {7'b0, macAckReq}, 8'h01);
    rdReg(2'd0, d); chk("R2 ctrl readback", d, 8'h05);
    repeat (2) @(negedge clk);
    chk("R3 held", {7'b0, macReq}, 8'h01);
    @(negedge clk); macAccept = 1'b1;
    @(negedge clk); macAccept = 1'b0;
    chk("R3 dropped", {7'b0, macReq}, 8'h00);
    rdReg(2'd0, d); chk("R3 ctrl self-clear", d, 8'h04);

    // R10 only two mask bits
    wrReg(2'd3, 8'hFF); rdReg(2'd3, d); chk("R10 mask bits", d, 8'h09);
    wrReg(2'd3, 8'h00); rdReg(2'd3, d); chk("R10 mask clear", d, 8'h00);

    // R5 R6 R9 failed completion with interrupt
    pulseDone(1'b1);
    chk("R9 irq on done", {7'b0, irqN}, 8'h00);
    rdReg(2'd1, d); chk("R6 fail", d, 8'h01);
    rdReg(2'd2, d); chk("R7 read value", d, 8'h01);
    chk("R7 irq released", {7'b0, irqN}, 8'h01);
    rdReg(2'd2, d); chk("R7 cleared", d, 8'h00);
    rdReg(2'd1, d); chk("R6 holds", d, 8'h01);

    // R6 new trigger clears result
    wrReg(2'd0, 8'h01);
    chk("R4 ack off", {7'b0, macAckReq}, 8'h00);
    rdReg(2'd1, d); chk("R6 cleared by trigger", d, 8'h00);
    @(negedge clk); macAccept = 1'b1;
    @(negedge clk); macAccept = 1'b0;

    // R11 read-only registers
    pulseDone(1'b1);
    rdReg(2'd2, d);
    wrReg(2'd1, 8'h00); wrReg(2'd2, 8'hFF);
    rdReg(2'd1, d); chk("R11 result write ignored", d, 8'h01);
    rdReg(2'd2, d); chk("R11 event write ignored", d, 8'h00);
    chk("R11 irq", {7'b0, irqN}, 8'h01);

    // R9 masked event stays visible, R5 rx event
    wrReg(2'd3, 8'h01);
    pulseDone(1'b0);
    chk("R9 masked quiet", {7'b0, irqN}, 8'h01);
    rdReg(2'd1, d); chk("R6 success", d, 8'h00);
    pulseRx();
    chk("R9 rx unmasked", {7'b0, irqN}, 8'h00);
    rdReg(2'd2, d); chk("R5 both events", d, 8'h09);

    // R8 event during clearing read
    @(negedge clk); regAddr = 2'd2; regRd = 1'b1; rxEvent = 1'b1; #1 d = regRdata;
    @(negedge clk); regRd = 1'b0; rxEvent = 1'b0;
    chk("R8 read value", d, 8'h00);
    rdReg(2'd2, d); chk("R8 kept", d, 8'h08);

    // random mix against model
    mEv0 = 1'b0; mEv1 = 1'b0; mMk0 = 1'b1; mMk1 = 1'b0; mFail = 1'b0;
    for (int n = 0; n < 400; n++) begin
      logic dn, fl, rx, rd, wm;
      logic [1:0] a;
      logic [7:0] wd;
      @(negedge clk);
      chk("R9 random irq", {7'b0, irqN}, {7'b0, ~((mEv0 & ~mMk0) | (mEv1 & ~mMk1))});
      dn = ($urandom % 5) == 0; fl = $urandom % 2; rx = ($urandom % 5) == 0;
      a = 2'($urandom % 4); rd = ($urandom % 2) == 0 && a != 2'd0;
      wm = !rd && a == 2'd3 && ($urandom % 2) == 0;
      wd = 8'($urandom);
      macDone = dn; macFail = fl; rxEvent = rx; regAddr = a; regRd = rd;
      regWr = wm; regWdata = wd;
      #1;
      if (rd) begin
        if (a == 2'd1) chk("R6 random result", regRdata, {7'b0, mFail});
        else if (a == 2'd2) chk("R7 random events", regRdata, evtByte(mEv0, mEv1));
        else chk("R10 random mask", regRdata, evtByte(mMk0, mMk1));
      end
      mEv0 = dn | (mEv0 & ~(rd && a == 2'd2));
      mEv1 = rx | (mEv1 & ~(rd && a == 2'd2));
      if (dn) mFail = fl;
      if (wm) begin mMk0 = wd[0]; mMk1 = wd[3]; end
    end
    @(negedge clk);
    macDone = 1'b0; rxEvent = 1'b0; regRd = 1'b0; regWr = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule